// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Output

This block is a 16-bit up-counter paired with a 16-bit holding register. One 8-bit control byte picks how the pair behaves. In auto-reload mode the holding register is copied into the counter on overflow. In capture mode a falling edge on an external trigger copies the counter into the holding register. In baud mode the counter free-runs between reloads and drives serial receive and transmit clocks with its overflow pulses. The counter advances on either a prescaled internal tick or falling edges of an external count pin.

Software reaches the control byte, the two counter bytes and the two holding bytes through a byte-wide port with a 3-bit address. Writes take one clock and reads are combinational. An interrupt request stays high while either event flag is set. Both external pins pass through a synchronizer before their edges are detected.

Top module: `crt_timer`

## Requirements
- R1: After reset every register reads 0x00 and `irq`, `baud_ovf`, `rx_clk` and `tx_clk` are low (with `t1_ovf_i` low).
- R2: Address 0 is the control byte, 1 and 2 are the counter low and high bytes, and 3 and 4 are the holding low and high bytes. Addresses 5 to 7 read 0x00 and writes to them have no effect. Control bits are: 7 overflow flag, 6 trigger flag, 5 receive select, 4 transmit select, 3 trigger enable, 2 run, 1 external count, 0 capture mode.
- R3: With run=1 and external count=0, the counter advances by one on each clock in which `tick_i` is high.
- R4: With run=1 and external count=1, the counter advances on each falling edge of `cnt_in`. The new value is readable after the third rising clock edge following the input's fall, and not after the second.
- R5: In reload mode (capture mode=0, both selects 0), an overflow from 0xFFFF loads the holding register into the counter and sets the overflow flag.
- R6: In capture mode with trigger enable=1 and run=1, a falling edge on `trig_in` copies the counter into the holding register and sets the trigger flag. An overflow there wraps the counter to 0x0000 and sets the overflow flag.
- R7: In reload mode with trigger enable=1 and run=1, a falling edge on `trig_in` loads the holding register into the counter and sets the trigger flag.
- R8: With trigger enable=0, edges on `trig_in` change neither the holding register, the counter nor the trigger flag.
- R9: With either select set, an overflow always reloads the counter, whatever the capture mode bit says, and does not set the overflow flag. Trigger edges are ignored. `baud_ovf` pulses for one cycle in the clock after the overflow.
- R10: `rx_clk` carries `baud_ovf` when receive select is 1 and otherwise `t1_ovf_i`. `tx_clk` likewise follows transmit select.
- R11: `irq` is high exactly when the overflow flag or the trigger flag is 1.
- R12: With run=0 the counter holds and trigger edges are ignored.
- R13: A software write to a byte wins over a hardware update of that byte in the same cycle. The other byte of the pair still takes its hardware update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled internal count tick, one clock wide |
| cnt_in | input | 1 | External count pin (asynchronous) |
| trig_in | input | 1 | External capture/reload trigger pin (asynchronous) |
| t1_ovf_i | input | 1 | Overflow pulse of the other timer, used when a select is 0 |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request |
| baud_ovf | output | 1 | Overflow pulse in baud mode |
| rx_clk | output | 1 | Serial receive clock source |
| tx_clk | output | 1 | Serial transmit clock source |

## Verification
The bench builds the block with its default synchronizer depth of two stages. This fixes the pin-to-count latency at three edges, so the directed latency checks can count it exactly. A behavioural model runs beside the design and is compared on every clock. Directed phases preload the counter near 0xFFFF through the register port, so overflow, reload, wrap and baud pulses are reached in a few ticks. A long random phase then mixes writes, ticks and pin edges, including same-cycle write and event collisions.

// File: rtl/crt_timer.sv
module crt_timer #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       cnt_in,
  input  logic       trig_in,
  input  logic       t1_ovf_i,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       baud_ovf,
  output logic       rx_clk,
  output logic       tx_clk
);
  localparam logic [2:0] A_CTL = 3'd0, A_CLO = 3'd1, A_CHI = 3'd2, A_RLO = 3'd3, A_RHI = 3'd4;
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] c_sync, t_sync;
  logic c_prev, t_prev;
  logic [7:0]  ctl;
  logic [15:0] count, hold;
  logic        pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_sync <= '0;
      t_sync <= '0;
      c_prev <= 1'b0;
      t_prev <= 1'b0;
    end else begin
      c_sync <= {c_sync[TOP-1:0], cnt_in};
      t_sync <= {t_sync[TOP-1:0], trig_in};
      c_prev <= c_sync[TOP];
      t_prev <= t_sync[TOP];
    end
  end

  wire c_fall   = c_prev & ~c_sync[TOP];
  wire t_fall   = t_prev & ~t_sync[TOP];
  wire run      = ctl[2];
  wire cap_mode = ctl[0];
  wire baud     = ctl[5] | ctl[4];
  wire inc      = run & (ctl[1] ? c_fall : tick_i);
  wire ovf      = inc & (count == 16'hFFFF);
  wire trig_evt = run & ctl[3] & ~baud & t_fall;
  wire do_load  = (ovf & (baud | ~cap_mode)) | (trig_evt & ~cap_mode);
  wire do_cap   = trig_evt & cap_mode;

  wire wr_ctl = wr_en & (addr == A_CTL);
  wire wr_clo = wr_en & (addr == A_CLO);
  wire wr_chi = wr_en & (addr == A_CHI);
  wire wr_rlo = wr_en & (addr == A_RLO);
  wire wr_rhi = wr_en & (addr == A_RHI);

  logic [15:0] count_hw, hold_hw;
  logic [7:0]  ctl_hw;

  always_comb begin
    count_hw = count;
    if (do_load)  count_hw = hold;
    else if (inc) count_hw = count + 16'd1;
    hold_hw = do_cap ? count : hold;
    ctl_hw  = ctl;
    if (ovf & ~baud) ctl_hw[7] = 1'b1;
    if (trig_evt)    ctl_hw[6] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= '0;
      count   <= '0;
      hold    <= '0;
      pulse_q <= 1'b0;
    end else begin
      ctl         <= wr_ctl ? wdata : ctl_hw;
      count[7:0]  <= wr_clo ? wdata : count_hw[7:0];
      count[15:8] <= wr_chi ? wdata : count_hw[15:8];
      hold[7:0]   <= wr_rlo ? wdata : hold_hw[7:0];
      hold[15:8]  <= wr_rhi ? wdata : hold_hw[15:8];
      pulse_q     <= ovf & baud;
    end
  end

  always_comb begin
    case (addr)
      A_CTL:   rdata = ctl;
      A_CLO:   rdata = count[7:0];
      A_CHI:   rdata = count[15:8];
      A_RLO:   rdata = hold[7:0];
      A_RHI:   rdata = hold[15:8];
      default: rdata = 8'h00;
    endcase
  end

  assign irq      = ctl[7] | ctl[6];
  assign baud_ovf = pulse_q;
  assign rx_clk   = ctl[5] ? pulse_q : t1_ovf_i;
  assign tx_clk   = ctl[4] ? pulse_q : t1_ovf_i;

  wire wr_cnt = wr_clo | wr_chi;

  AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && (baud || !cap_mode) && !wr_cnt) |=> count == $past(hold)); // R5
  AST_BAUD_NO_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (baud && !ctl[7] && !wr_ctl) |=> !ctl[7]); // R9
  AST_TRIG_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[3] && !ctl[6] && !wr_ctl) |=> !ctl[6]); // R8
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(count)); // R12
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    baud_ovf |=> !baud_ovf || $past(ovf)); // R9
endmodule

// File: tb/crt_timer_tb.sv
module crt_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 0, cnt_in = 0, trig_in = 0, t1_ovf_i = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq, baud_ovf, rx_clk, tx_clk;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  crt_timer u_dut (.clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_in(cnt_in), .trig_in(trig_in),
    .t1_ovf_i(t1_ovf_i), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq),
    .baud_ovf(baud_ovf), .rx_clk(rx_clk), .tx_clk(tx_clk));

  // behavioural reference
  logic [15:0] m_cnt = 0, m_cap = 0;
  logic [7:0]  m_ctl = 0;
  bit m_pulse = 0, c0 = 0, c1 = 0, cp = 0, g0 = 0, g1 = 0, gp = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cap = 0; m_ctl = 0; m_pulse = 0;
      c0 = 0; c1 = 0; cp = 0; g0 = 0; g1 = 0; gp = 0;
    end else begin
      bit cf, gf, is_run, is_baud, step_up, wrap, trig;
      logic [15:0] n_cnt, n_cap;
      logic [7:0] n_ctl;
      cf = cp && !c1;
      gf = gp && !g1;
      is_run  = m_ctl[2];
      is_baud = m_ctl[5] || m_ctl[4];
      step_up = is_run && (m_ctl[1] ? cf : tick_i);
      wrap    = step_up && (m_cnt == 16'hFFFF);
      trig    = is_run && m_ctl[3] && !is_baud && gf;
      n_cnt = m_cnt; n_cap = m_cap; n_ctl = m_ctl;
      if (wrap && (is_baud || !m_ctl[0])) n_cnt = m_cap;
      else if (trig && !m_ctl[0]) n_cnt = m_cap;
      else if (step_up) n_cnt = m_cnt + 16'd1;
      if (trig && m_ctl[0]) n_cap = m_cnt;
      if (wrap && !is_baud) n_ctl[7] = 1'b1;
      if (trig) n_ctl[6] = 1'b1;
      if (wr_en) begin
        case (addr)
          3'd0: n_ctl = wdata;
          3'd1: n_cnt[7:0] = wdata;
          3'd2: n_cnt[15:8] = wdata;
          3'd3: n_cap[7:0] = wdata;
          3'd4: n_cap[15:8] = wdata;
          default: ;
        endcase
      end
      m_cnt = n_cnt; m_cap = n_cap; m_ctl = n_ctl;
      m_pulse = wrap && is_baud;
      cp = c1; c1 = c0; c0 = cnt_in;
      gp = g1; g1 = g0; g0 = trig_in;
    end
  end

  function automatic logic [7:0] m_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_ctl;
      3'd1: return m_cnt[7:0];
      3'd2: return m_cnt[15:8];
      3'd3: return m_cap[7:0];
      3'd4: return m_cap[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(irq == (m_ctl[7] | m_ctl[6]), "R11 irq vs model", irq, m_ctl[7] | m_ctl[6]);
    chk(baud_ovf == m_pulse, "R9 baud_ovf vs model", baud_ovf, m_pulse);
    chk(rx_clk == (m_ctl[5] ? m_pulse : t1_ovf_i), "R10 rx_clk vs model", rx_clk, m_ctl[5] ? m_pulse : t1_ovf_i);
    chk(tx_clk == (m_ctl[4] ? m_pulse : t1_ovf_i), "R10 tx_clk vs model", tx_clk, m_ctl[4] ? m_pulse : t1_ovf_i);
    chk(rdata == m_rd(addr), "R2 rdata vs model", rdata, m_rd(addr));
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1; step(); wr_en = 0;
  endtask

  task automatic rd16(input logic [2:0] a, input logic [15:0] exp, input string tag);
    logic [15:0] v;
    addr = a; #1; v[7:0] = rdata;
    addr = a + 3'd1; #1; v[15:8] = rdata;
    chk(v == exp, tag, v, exp);
  endtask

  task automatic rd8(input logic [2:0] a, input logic [7:0] exp, input string tag);
    addr = a; #1;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic pin_fall(input bit use_trig);
    if (use_trig) trig_in = 1; else cnt_in = 1;
    repeat (3) step();
    if (use_trig) trig_in = 0; else cnt_in = 0;
    repeat (3) step();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd8(0, 8'h00, "R1 ctl reset");
    rd16(1, 16'h0000, "R1 count reset");
    rd16(3, 16'h0000, "R1 hold reset");
    chk(!irq && !baud_ovf && !rx_clk && !tx_clk, "R1 outputs reset", {irq, baud_ovf, rx_clk, tx_clk}, 0);

    // R2 register map
    wr(3, 8'hF0); wr(4, 8'hFF); wr(1, 8'hFE); wr(2, 8'hFF);
    rd16(1, 16'hFFFE, "R2 count readback");
    rd16(3, 16'hFFF0, "R2 hold readback");
    wr(6, 8'h55);
    rd8(6, 8'h00, "R2 unmapped reads zero");
    rd16(1, 16'hFFFE, "R2 unmapped write no effect");

    // R3 / R5 reload on wrap
    wr(0, 8'h04);
    tick_i = 1; step();
    rd16(1, 16'hFFFF, "R3 tick increments");
    step(); tick_i = 0;
    rd16(1, 16'hFFF0, "R5 reload on wrap");
    rd8(0, 8'h84, "R5 overflow flag set");
    chk(irq == 1, "R11 irq on flag", irq, 1);

    // R13 write priority
    tick_i = 1; addr = 1; wdata = 8'h10; wr_en = 1; step(); wr_en = 0; tick_i = 0;
    rd16(1, 16'hFF10, "R13 write wins over increment");

    // R12 stopped
    wr(0, 8'h00);
    tick_i = 1; repeat (5) step(); tick_i = 0;
    rd16(1, 16'hFF10, "R12 stopped holds");

    // R6 capture with latency
    wr(0, 8'h0D);
    trig_in = 1; repeat (3) step();
    trig_in = 0; repeat (2) step();
    rd16(3, 16'hFFF0, "R6 no capture before third edge");
    step();
    rd16(3, 16'hFF10, "R6 capture copies count");
    rd8(0, 8'h4D, "R6 trigger flag set");
    rd16(1, 16'hFF10, "R6 count unchanged by capture");
    wr(1, 8'hFF); wr(2, 8'hFF);
    tick_i = 1; step(); tick_i = 0;
    rd16(1, 16'h0000, "R6 wrap to zero in capture");
    rd8(0, 8'hCD, "R6 overflow flag in capture");

    // R8 trigger disabled
    wr(0, 8'h05);
    pin_fall(1);
    rd16(3, 16'hFF10, "R8 hold untouched");
    rd8(0, 8'h05, "R8 no trigger flag");
    chk(irq == 0, "R11 irq low when flags clear", irq, 0);

    // R7 trigger reload
    wr(0, 8'h0C);
    pin_fall(1);
    rd16(1, 16'hFF10, "R7 trigger reload");
    rd8(0, 8'h4C, "R7 trigger flag");

    // R4 external count
    wr(0, 8'h06); wr(1, 8'h00); wr(2, 8'h00);
    cnt_in = 1; repeat (3) step();
    cnt_in = 0; repeat (2) step();
    rd16(1, 16'h0000, "R4 not yet after two edges");
    step();
    rd16(1, 16'h0001, "R4 count after third edge");
    pin_fall(0); pin_fall(0);
    rd16(1, 16'h0003, "R4 three falls counted");

    // R9 baud mode
    wr(3, 8'hFE); wr(4, 8'hFF); wr(1, 8'hFF); wr(2, 8'hFF); wr(0, 8'h3D);
    tick_i = 1; step(); tick_i = 0;
    chk(baud_ovf && rx_clk && tx_clk, "R9 baud pulse after wrap", {baud_ovf, rx_clk, tx_clk}, 7);
    rd16(1, 16'hFFFE, "R9 forced reload");
    rd8(0, 8'h3D, "R9 no overflow flag");
    step();
    chk(!baud_ovf, "R9 pulse is one cycle", baud_ovf, 0);
    pin_fall(1);
    rd16(1, 16'hFFFE, "R9 trigger ignored count");
    rd8(0, 8'h3D, "R9 trigger ignored flag");

    // R10 routing
    wr(0, 8'h24);
    t1_ovf_i = 1; #1;
    chk(!rx_clk && tx_clk, "R10 tx follows other timer", {rx_clk, tx_clk}, 1);
    tick_i = 1; step(); step(); tick_i = 0; t1_ovf_i = 0; #1;
    chk(rx_clk && !tx_clk, "R10 rx follows own overflow", {rx_clk, tx_clk}, 2);

    // random phase (R3 R5 R6 R7 R13 via model)
    for (int i = 0; i < 4000; i++) begin
      tick_i = ($urandom % 3) == 0;
      if (($urandom % 5) == 0) cnt_in = ~cnt_in;
      if (($urandom % 7) == 0) trig_in = ~trig_in;
      t1_ovf_i = ($urandom % 6) == 0;
      wr_en = ($urandom % 6) == 0;
      addr = 3'($urandom % 8);
      wdata = 8'($urandom);
      if (wr_en && addr == 3'd2 && ($urandom % 2)) wdata = 8'hFF;
      if (wr_en && addr == 3'd0) wdata[2] = ($urandom % 4) != 0;
      step();
    end
    wr_en = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule